// File: doc/BRIEF.md
# Constant Buffer Bind and Upload Controller

This block sits behind the method decoder of a 3D command engine. Each accepted method is an address/argument pair. A handful of method addresses load the working registers for constant buffers: the buffer size, the two halves of the buffer base address, and a running write offset. A window of sixteen data methods streams argument words into memory at base plus offset. The offset moves on by four bytes after every word that is written.

A bind method copies the current size and base into one entry of a slot table, together with an enable flag, so that later stages can look up where each constant buffer lives. A combinational read port returns the enable, base and size of any slot. The block also serves a query-control method: in its plain write mode it stores a sequence value to a separately programmed address.

Address translation is modelled by a single valid flag that is sampled with each method. Memory writes leave the block one at a time on a valid/ready channel. No method is accepted while a write is still outstanding.

Top module: `cbuf_bind_ctrl`

## Requirements
- R1: After reset, `wr_valid` is 0, `mth_ready` is 1, and every slot reads back with enable 0, base 0 and size 0.
- R2: An accepted data method (address 0x8E4 through 0x8F3) with `xlat_ok` high raises `wr_valid` on the next cycle. It presents the method argument on `wr_data` and base plus offset on `wr_addr`, with the offset zero-extended to 64 bits.
- R3: Each issued data write advances the stored offset by 4, so the next data method in the window writes 4 bytes higher. Any address in the 16-method window counts. Method 0x8F4 is outside the window and issues no write.
- R4: A method at 0x8E3 replaces the write offset with its argument, and the next data write uses that offset.
- R5: The base address is the argument of method 0x8E1 placed in bits 63:32, with the argument of method 0x8E2 in bits 31:0 taken as unsigned. Bit 31 of the low word does not extend into the high word. Method 0x8E0 holds the size.
- R6: A data method accepted while `xlat_ok` is low issues no write and leaves the offset unchanged.
- R7: A bind method at 0x904 uses argument bit 0 as the enable flag and bits 8:4 as the slot index. The selected slot takes that enable flag and the current size register.
- R8: A bind copies the current base into the slot only when `xlat_ok` is high. Otherwise the slot keeps its previous base, while its enable and size are still updated.
- R9: A bind with slot index 18 or more changes no slot. Reading a slot index of 18 or more returns all zeros.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. `mth_ready` is low whenever `wr_valid` is high. The request drops in the cycle after `wr_ready` is seen.
- R11: A method at 0x6C3 whose argument bits 1:0 are 0, accepted with `xlat_ok` high, writes the value held by method 0x6C2 to the address built from 0x6C0 (high word) and 0x6C1 (low word). Any other mode issues no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mth_valid | input | 1 | Method pair offered |
| mth_ready | output | 1 | Method accepted this cycle when valid |
| mth_addr | input | 12 | Method address |
| mth_data | input | 32 | Method argument |
| xlat_ok | input | 1 | Address translation currently valid |
| wr_valid | output | 1 | Memory write request pending |
| wr_ready | input | 1 | Memory takes the request |
| wr_addr | output | 64 | Byte address of the write |
| wr_data | output | 32 | Word to write |
| rd_slot | input | 5 | Slot selected on the read port |
| rd_en | output | 1 | Enable flag of the selected slot |
| rd_base | output | 64 | Bound base address of the selected slot |
| rd_size | output | 32 | Bound size of the selected slot |

## Verification
A memory write is due one cycle after the method that causes it is accepted. It stays on the port until the cycle after `wr_ready` is high. Register loads and slot binds take effect at the accepting edge, so the read port shows the new slot contents as soon as the driver task returns. The bench predicts each write when it offers the method, queues the prediction, and compares it in a monitor at the falling edge on which the handshake completes. Writes that should be dropped are confirmed by waiting several cycles and checking that `wr_valid` stays low and the queue stays empty.

// File: rtl/cbuf_pkg.sv
// Shared constants and types for the constant-buffer controller.
// Assumes 32-bit method arguments and 12-bit method addresses.
package cbuf_pkg;

    localparam int MTH_W    = 12;
    localparam int DW       = 32;
    localparam int AW       = 2 * DW;
    localparam int SLOT_W   = 5;
    localparam int DATA_WIN = 16;
    localparam int OFF_STEP = 4;

    localparam logic [MTH_W-1:0] M_CB_SIZE    = 12'h8E0;
    localparam logic [MTH_W-1:0] M_CB_ADDR_HI = 12'h8E1;
    localparam logic [MTH_W-1:0] M_CB_ADDR_LO = 12'h8E2;
    localparam logic [MTH_W-1:0] M_CB_OFFSET  = 12'h8E3;
    localparam logic [MTH_W-1:0] M_CB_DATA0   = 12'h8E4;
    localparam logic [MTH_W-1:0] M_CB_DATAN   = M_CB_DATA0 + MTH_W'(DATA_WIN - 1);
    localparam logic [MTH_W-1:0] M_CB_BIND    = 12'h904;
    localparam logic [MTH_W-1:0] M_Q_ADDR_HI  = 12'h6C0;
    localparam logic [MTH_W-1:0] M_Q_ADDR_LO  = 12'h6C1;
    localparam logic [MTH_W-1:0] M_Q_SEQ      = 12'h6C2;
    localparam logic [MTH_W-1:0] M_Q_CTRL     = 12'h6C3;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
        logic [DW-1:0] size;
    } slot_t;

endpackage

// File: rtl/cbuf_mth_regs.sv
// Method register bank: decodes method addresses and holds the size,
// base halves, running offset and query registers.
// Assumes acc is high only for a method accepted this cycle.
module cbuf_mth_regs
    import cbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [MTH_W-1:0] mth_addr,
    input  logic [DW-1:0]    mth_data,
    input  logic             xlat_ok,
    output logic             is_data,
    output logic             is_bind,
    output logic             is_query,
    output logic [DW-1:0]    cb_size,
    output logic [DW-1:0]    cb_off,
    output logic [AW-1:0]    cb_base,
    output logic [DW-1:0]    q_seq,
    output logic [AW-1:0]    q_base
);

    logic [DW-1:0] size_q, hi_q, lo_q, off_q;
    logic [DW-1:0] qhi_q, qlo_q, seq_q;

    // Classify the incoming method address.
    always_comb begin
        is_data  = (mth_addr >= M_CB_DATA0) && (mth_addr <= M_CB_DATAN);
        is_bind  = (mth_addr == M_CB_BIND);
        is_query = (mth_addr == M_Q_CTRL);
    end

    // Load registers from accepted methods; step the offset on issued data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            off_q  <= '0;
            qhi_q  <= '0;
            qlo_q  <= '0;
            seq_q  <= '0;
        end else if (acc) begin
            case (mth_addr)
                M_CB_SIZE:    size_q <= mth_data;
                M_CB_ADDR_HI: hi_q   <= mth_data;
                M_CB_ADDR_LO: lo_q   <= mth_data;
                M_CB_OFFSET:  off_q  <= mth_data;
                M_Q_ADDR_HI:  qhi_q  <= mth_data;
                M_Q_ADDR_LO:  qlo_q  <= mth_data;
                M_Q_SEQ:      seq_q  <= mth_data;
                default: begin
                    if (is_data && xlat_ok)
                        off_q <= off_q + DW'(OFF_STEP);
                end
            endcase
        end
    end

    // Present the assembled 64-bit addresses (low half unsigned).
    always_comb begin
        cb_size = size_q;
        cb_off  = off_q;
        cb_base = {hi_q, lo_q};
        q_seq   = seq_q;
        q_base  = {qhi_q, qlo_q};
    end

endmodule

// File: rtl/cbuf_slot_table.sv
// Binding table: one entry per slot holding enable, base and size.
// Assumes SLOTS fits the slot index field; indices beyond SLOTS-1 match no entry.
module cbuf_slot_table
    import cbuf_pkg::*;
#(
    parameter int SLOTS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bind_we,
    input  logic              bind_en,
    input  logic [SLOT_W-1:0] bind_idx,
    input  logic              xlat_ok,
    input  logic [AW-1:0]     cur_base,
    input  logic [DW-1:0]     cur_size,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_t             rd_entry
);

    slot_t tbl [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = bind_we && (bind_idx == SLOT_W'(g));

        // Update this slot on a matching bind; base only under valid translation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= '0;
            end else if (hit) begin
                tbl[g].en   <= bind_en;
                tbl[g].size <= cur_size;
                if (xlat_ok)
                    tbl[g].base <= cur_base;
            end
        end
    end

    // Select the addressed slot for the read port; out of range reads zero.
    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i))
                rd_entry = tbl[i];
        end
    end

endmodule

// File: rtl/cbuf_wr_req.sv
// Single-entry memory write request register with valid/ready handshake.
// Assumes issue is never raised while a request is pending.
module cbuf_wr_req
    import cbuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_data,
    input  logic          wr_ready,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    // Capture a new request or retire the current one on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (issue) begin
            wr_valid <= 1'b1;
            wr_addr  <= issue_addr;
            wr_data  <= issue_data;
        end else if (wr_valid && wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/cbuf_bind_ctrl.sv
// Constant-buffer bind and upload controller top level.
// Accepts methods, streams data words and query results to memory,
// and maintains the slot binding table. Assumes one method per cycle at most.
module cbuf_bind_ctrl
    import cbuf_pkg::*;
#(
    parameter int SLOTS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mth_valid,
    output logic              mth_ready,
    input  logic [MTH_W-1:0]  mth_addr,
    input  logic [DW-1:0]     mth_data,
    input  logic              xlat_ok,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_en,
    output logic [AW-1:0]     rd_base,
    output logic [DW-1:0]     rd_size
);

    logic          acc, is_data, is_bind, is_query;
    logic [DW-1:0] cb_size, cb_off, q_seq;
    logic [AW-1:0] cb_base, q_base;
    logic          issue_data, issue_qry, issue;
    logic [AW-1:0] issue_addr;
    logic [DW-1:0] issue_word;
    slot_t         rd_entry;

    // Accept methods only while no write is outstanding.
    always_comb begin
        mth_ready = !wr_valid;
        acc       = mth_valid && mth_ready;
    end

    cbuf_mth_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .mth_addr (mth_addr),
        .mth_data (mth_data),
        .xlat_ok  (xlat_ok),
        .is_data  (is_data),
        .is_bind  (is_bind),
        .is_query (is_query),
        .cb_size  (cb_size),
        .cb_off   (cb_off),
        .cb_base  (cb_base),
        .q_seq    (q_seq),
        .q_base   (q_base)
    );

    // Choose what, if anything, goes out as a memory write.
    always_comb begin
        issue_data = acc && is_data && xlat_ok;
        issue_qry  = acc && is_query && (mth_data[1:0] == 2'b00) && xlat_ok;
        issue      = issue_data || issue_qry;
        issue_addr = issue_qry ? q_base : (cb_base + {{(AW-DW){1'b0}}, cb_off});
        issue_word = issue_qry ? q_seq : mth_data;
    end

    cbuf_wr_req u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_addr (issue_addr),
        .issue_data (issue_word),
        .wr_ready   (wr_ready),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    cbuf_slot_table #(.SLOTS(SLOTS)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bind_we  (acc && is_bind),
        .bind_en  (mth_data[0]),
        .bind_idx (mth_data[8:4]),
        .xlat_ok  (xlat_ok),
        .cur_base (cb_base),
        .cur_size (cb_size),
        .rd_slot  (rd_slot),
        .rd_entry (rd_entry)
    );

    // Unpack the selected slot onto the read port.
    always_comb begin
        rd_en   = rd_entry.en;
        rd_base = rd_entry.base;
        rd_size = rd_entry.size;
    end

endmodule

// File: rtl/cbuf_bind_ctrl_chk.sv
// Protocol checker for cbuf_bind_ctrl, attached through bind.
module cbuf_bind_ctrl_chk
    import cbuf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mth_valid,
    input logic              mth_ready,
    input logic [MTH_W-1:0]  mth_addr,
    input logic [DW-1:0]     mth_data,
    input logic              xlat_ok,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [SLOT_W-1:0] rd_slot,
    input logic              rd_en,
    input logic [AW-1:0]     rd_base,
    input logic [DW-1:0]     rd_size
);

    logic taken, in_win;
    assign taken  = mth_valid && mth_ready;
    assign in_win = (mth_addr >= M_CB_DATA0) && (mth_addr <= M_CB_DATAN);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && mth_ready && !rd_en));

    assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && in_win && xlat_ok) |=> (wr_valid && wr_data == $past(mth_data)));

    assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && in_win && !xlat_ok) |=> !wr_valid);

    assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !mth_ready);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_valid);

    assert_query_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && mth_addr == M_Q_CTRL && mth_data[1:0] != 2'b00) |=> !wr_valid);

endmodule

bind cbuf_bind_ctrl cbuf_bind_ctrl_chk u_chk (.*);

// File: tb/cbuf_bind_ctrl_test.sv
`timescale 1ns/1ps
module cbuf_bind_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mth_valid = 1'b0;
    logic        mth_ready;
    logic [11:0] mth_addr = '0;
    logic [31:0] mth_data = '0;
    logic        xlat_ok = 1'b1;
    logic        wr_valid;
    logic        wr_ready;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic [4:0]  rd_slot = '0;
    logic        rd_en;
    logic [63:0] rd_base;
    logic [31:0] rd_size;

    int checks = 0;
    int fails  = 0;
    bit stall  = 0;
    int cyc    = 0;

    // Reference model state
    logic [31:0] m_size = 0, m_hi = 0, m_lo = 0, m_off = 0;
    logic [31:0] m_qhi = 0, m_qlo = 0, m_seq = 0;
    logic        s_en   [18];
    logic [63:0] s_base [18];
    logic [31:0] s_size [18];

    logic [95:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    cbuf_bind_ctrl uut (.*);

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Ready generator: always ready, or one cycle in three when stalling.
    initial begin
        wr_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            cyc++;
            wr_ready = stall ? (cyc % 3 == 0) : 1'b1;
        end
    end

    // Monitor: compare completed writes with predictions; check hold while stalled.
    initial begin
        bit          pend = 0;
        logic [95:0] held = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend)
                    chk(wr_valid && {wr_addr, wr_data} == held, "R10 hold",
                        {95'b0, wr_valid} ^ {wr_addr, wr_data}, held);
                if (wr_valid && wr_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected write", {wr_addr, wr_data}, '0);
                    end else begin
                        logic [95:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
                    end
                end
                pend = wr_valid && !wr_ready;
                held = {wr_addr, wr_data};
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    // Offer one method, update the model, and wait for acceptance.
    task automatic mth(input logic [11:0] a, input logic [31:0] d, input logic xl, input string tag);
        bit go;
        if (a >= 12'h8E4 && a <= 12'h8F3) begin
            if (xl) begin
                exp_q.push_back({({m_hi, m_lo} + {32'b0, m_off}), d});
                tag_q.push_back(tag);
                m_off = m_off + 4;
            end
        end else begin
            case (a)
                12'h8E0: m_size = d;
                12'h8E1: m_hi   = d;
                12'h8E2: m_lo   = d;
                12'h8E3: m_off  = d;
                12'h6C0: m_qhi  = d;
                12'h6C1: m_qlo  = d;
                12'h6C2: m_seq  = d;
                12'h6C3: if (d[1:0] == 2'b00 && xl) begin
                    exp_q.push_back({m_qhi, m_qlo, m_seq});
                    tag_q.push_back(tag);
                end
                12'h904: if (d[8:4] < 18) begin
                    s_en[d[8:4]]   = d[0];
                    s_size[d[8:4]] = m_size;
                    if (xl) s_base[d[8:4]] = {m_hi, m_lo};
                end
                default: ;
            endcase
        end
        mth_valid = 1'b1; mth_addr = a; mth_data = d; xlat_ok = xl;
        do begin
            @(negedge clk);
            go = mth_ready;
            @(posedge clk); #1;
        end while (!go);
        mth_valid = 1'b0; xlat_ok = 1'b1;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || wr_valid);
        @(posedge clk); #1;
    endtask

    task automatic check_slot(input int idx, input string req);
        logic [96:0] e, a;
        rd_slot = 5'(idx);
        #1;
        e = (idx < 18) ? {s_en[idx], s_base[idx], s_size[idx]} : '0;
        a = {rd_en, rd_base, rd_size};
        chk(a == e, req, a[95:0], e[95:0]);
    endtask

    task automatic quiet(input string req);
        repeat (3) @(negedge clk);
        chk(!wr_valid && exp_q.size() == 0, req, {95'b0, wr_valid}, '0);
        @(posedge clk); #1;
    endtask

    initial begin
        for (int i = 0; i < 18; i++) begin
            s_en[i] = 0; s_base[i] = 0; s_size[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!wr_valid && mth_ready, "R1 handshake", {94'b0, wr_valid, mth_ready}, 96'b1);
        @(posedge clk); #1;
        check_slot(0, "R1 slot0");
        check_slot(17, "R1 slot17");

        // R5: low word with bit 31 set stays unsigned
        mth(12'h8E0, 32'h0000_0100, 1, "R5");
        mth(12'h8E1, 32'h0000_0001, 1, "R5");
        mth(12'h8E2, 32'h8000_0000, 1, "R5");
        mth(12'h8E3, 32'h0000_0010, 1, "R4");
        // R2/R3: first, last and middle of the data window
        mth(12'h8E4, 32'hA5A5_0001, 1, "R2 first data method");
        mth(12'h8F3, 32'hA5A5_0002, 1, "R3 last data method");
        mth(12'h8EA, 32'hA5A5_0003, 1, "R3 offset step");
        drain();
        // R3: just past the window issues nothing
        mth(12'h8F4, 32'hDEAD_0000, 1, "R3");
        quiet("R3 method past window");

        // R10: stalled memory
        stall = 1;
        mth(12'h8E5, 32'h1111_0000, 1, "R10 stalled write");
        @(negedge clk);
        chk(!(wr_valid && mth_ready), "R10 backpressure", {94'b0, wr_valid, mth_ready}, 96'b10);
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++)
            mth(12'h8E6 + 12'(i), 32'h2222_0000 + 32'(i), 1, "R10 stalled burst");
        drain();
        stall = 0;

        // R6: dropped without translation, offset kept
        mth(12'h8E7, 32'hBAD0_0000, 0, "R6");
        quiet("R6 dropped write");
        mth(12'h8E7, 32'h6666_0006, 1, "R6 offset unchanged");
        drain();

        // R4: offset rewrite
        mth(12'h8E3, 32'h0000_0000, 1, "R4");
        mth(12'h8E9, 32'h4444_0004, 1, "R4 new offset");
        drain();

        // R7: binds
        mth(12'h904, 32'h0000_0031, 1, "R7");
        check_slot(3, "R7 bind slot3");
        mth(12'h8E0, 32'h0000_0200, 1, "R7");
        mth(12'h904, 32'h0000_0111, 1, "R7");
        check_slot(17, "R7 bind slot17 boundary");
        // R8: no translation keeps base but updates enable and size
        mth(12'h8E2, 32'h0000_4000, 1, "R8");
        mth(12'h8E0, 32'h0000_0040, 1, "R8");
        mth(12'h904, 32'h0000_0030, 0, "R8");
        check_slot(3, "R8 base kept");
        // R9: out-of-range slots
        mth(12'h904, 32'h0000_0141, 1, "R9");
        mth(12'h904, 32'h0000_01F1, 1, "R9");
        check_slot(3, "R9 slot3 untouched");
        check_slot(17, "R9 slot17 untouched");
        check_slot(0, "R9 slot0 untouched");
        check_slot(20, "R9 read out of range");

        // R11: query writes
        mth(12'h6C0, 32'h0000_0002, 1, "R11");
        mth(12'h6C1, 32'hC000_4000, 1, "R11");
        mth(12'h6C2, 32'h0000_0055, 1, "R11");
        mth(12'h6C3, 32'h0000_0000, 1, "R11 query write");
        drain();
        mth(12'h6C3, 32'h0000_0002, 1, "R11");
        quiet("R11 other mode silent");
        mth(12'h6C3, 32'h0000_0000, 0, "R11");
        quiet("R11 no translation silent");

        chk(exp_q.size() == 0, "R2 queue empty", 96'(exp_q.size()), '0);
        summary();
    end

endmodule